// File: doc/BRIEF.md
# System Clock Control Register Block

This block is the register-controlled front end of a chip's clock source. Software programs it through a simple 32-bit write/read port. It holds four words: a general control word, an oscillator control word, a PLL control word and a PLL frequency word. From these it drives the enables and frequency settings of two PLL models and two oscillator models. It also drives a per-timer slow-clock select and a clock enable for the bus clock domain. The bus clock enable divides the primary PLL clock (`clk_i`) by a programmable ratio.

Lock and stable indications come back from the analog models asynchronously. They are synchronized and shown as read-only status bits. Two controls depend on a software-override bit, with opposite sense. The main oscillator enable acts only while its override bit is clear. The primary PLL enable acts only while its override bit is set; otherwise the PLL is kept running by hardware.

Top module: `sysclk_ctrl`

## Requirements
- R1: After reset, reads return control 0x0000_0000, oscillator 0x0010_0002, PLL 0x3000_0002 and frequency 0x0000_0000 (status inputs low), and `bus_clk_en_o` is high on every cycle.
- R2: Words decode at byte offsets 0x00 (control), 0x0C (oscillator), 0x10 (PLL) and 0x14 (frequency). Other offsets read zero and ignore writes. Undefined bits read zero, so writing all ones to control reads back 0x2AAA_E000.
- R3: `tmr_sel_o[i]` equals control bit 15+2i for timers i = 0..7.
- R4: Control bits 14:13 hold divider value n. `bus_clk_en_o` then pulses once every n+1 cycles, and n = 0 gives passthrough (high every cycle).
- R5: A new divider value is taken up only at the end of the current divided period, so the period running when the write lands is never shortened.
- R6: Oscillator word bit 0 is the main-oscillator override and bit 1 its enable. `main_osc_en_o` is high only when bit 1 is set and bit 0 is clear. Bit 19 drives `aux_osc_off_o` and bit 20 drives `osc_tmr_en_o`.
- R7: PLL word bit 0 is the primary-PLL override and bit 1 its enable. `pll_a_en_o` equals bit 1 while bit 0 is set, and is high while bit 0 is clear. Bit 28 drives `pll_b_en_o` and bit 29 drives `pll_tmr_en_o`.
- R8: Frequency word bits 13:8 drive `pll_a_mul_o`, bits 2:0 drive `pll_a_shift_o` and bits 29:24 drive `pll_b_mul_o`. Other bits read zero.
- R9: Status bit 2 of the oscillator word (main oscillator stable) and bit 2 of the PLL word (primary PLL locked) ignore writes. Each shows its input after SYNC_STAGES rising edges, two by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Primary PLL clock, also the register clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Write strobe, sampled on the rising edge |
| addr_i | input | ADDR_W | Byte offset for write and read |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| main_osc_ok_i | input | 1 | Main oscillator stable, asynchronous |
| pll_a_lock_i | input | 1 | Primary PLL locked, asynchronous |
| bus_clk_en_o | output | 1 | Bus clock enable, one pulse per divided period |
| tmr_sel_o | output | 8 | Slow clock select per timer |
| main_osc_en_o | output | 1 | Main oscillator enable |
| aux_osc_off_o | output | 1 | Secondary oscillator disable |
| osc_tmr_en_o | output | 1 | Oscillator start-up timer enable |
| pll_a_en_o | output | 1 | Primary PLL enable |
| pll_b_en_o | output | 1 | Secondary PLL enable |
| pll_tmr_en_o | output | 1 | PLL start-up timer enable |
| pll_a_mul_o | output | 6 | Primary PLL multiplier minus two |
| pll_a_shift_o | output | 3 | Primary PLL post-shift |
| pll_b_mul_o | output | 6 | Secondary PLL multiplier minus two |

## Verification
A write lands on the rising edge that samples `wr_i`. The stored word and every output derived from it are valid from the next falling edge, and read data is combinational. The bench therefore drives on a falling edge and checks on the following falling edge. Status bits lag their inputs by two rising edges, so the bench checks both one edge and two edges after the input changes. A divider change first finishes the running period. The bench counts pulses over 12 cycles only after a settling gap, and it checks the boundary case edge by edge from a known pulse, where the next pulse is due exactly four cycles later.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam int unsigned DW = 32;

  // byte offsets
  localparam int unsigned OFF_CTRL = 'h00;
  localparam int unsigned OFF_OSC  = 'h0C;
  localparam int unsigned OFF_PLL  = 'h10;
  localparam int unsigned OFF_FREQ = 'h14;

  // control word
  localparam int unsigned N_TMR     = 8;
  localparam int unsigned TSEL_LSB  = 15;
  localparam int unsigned TSEL_STEP = 2;
  localparam int unsigned DIV_LSB   = 13;
  localparam int unsigned DIV_W     = 2;

  // oscillator word
  localparam int unsigned OSC_OVR  = 0;
  localparam int unsigned OSC_EN   = 1;
  localparam int unsigned OSC_STAT = 2;
  localparam int unsigned OSC_AOFF = 19;
  localparam int unsigned OSC_TMR  = 20;

  // PLL word
  localparam int unsigned PLA_OVR  = 0;
  localparam int unsigned PLA_EN   = 1;
  localparam int unsigned PLA_STAT = 2;
  localparam int unsigned PLB_EN   = 28;
  localparam int unsigned PL_TMR   = 29;

  // frequency word
  localparam int unsigned MUL_W     = 6;
  localparam int unsigned SHIFT_W   = 3;
  localparam int unsigned AMUL_LSB  = 8;
  localparam int unsigned ASHIFT_LSB = 0;
  localparam int unsigned BMUL_LSB  = 24;

  // writable masks
  localparam logic [DW-1:0] CTRL_MASK = 32'h2AAA_E000;
  localparam logic [DW-1:0] OSC_MASK  = 32'h0018_0003;
  localparam logic [DW-1:0] PLL_MASK  = 32'h3000_0003;
  localparam logic [DW-1:0] FREQ_MASK = 32'h3F00_3F07;

  // reset values: overrides clear, enables set, divider passthrough
  localparam logic [DW-1:0] CTRL_RST = 32'h0000_0000;
  localparam logic [DW-1:0] OSC_RST  = 32'h0010_0002;
  localparam logic [DW-1:0] PLL_RST  = 32'h3000_0002;
  localparam logic [DW-1:0] FREQ_RST = 32'h0000_0000;
endpackage

// File: rtl/sysclk_sync.sv
module sysclk_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/sysclk_busdiv.sv
module sysclk_busdiv #(
  parameter int unsigned DIV_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_sel_i,
  output logic             ce_o,
  output logic [DIV_W-1:0] act_o,
  output logic [DIV_W-1:0] cnt_o
);
  logic [DIV_W-1:0] act_q, cnt_q;

  // new ratio loaded only on the last cycle of a period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      cnt_q <= '0;
    end else if (cnt_q == act_q) begin
      cnt_q <= '0;
      act_q <= div_sel_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ce_o  = (cnt_q == '0);
  assign act_o = act_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/sysclk_regs.sv
module sysclk_regs
  import sysclk_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              osc_stat_i,
  input  logic              pla_stat_i,
  output logic [DW-1:0]     ctrl_o,
  output logic [DW-1:0]     osc_o,
  output logic [DW-1:0]     pll_o,
  output logic [DW-1:0]     freq_o,
  output logic [DW-1:0]     rdata_o
);
  logic [DW-1:0] ctrl_q, osc_q, pll_q, freq_q;
  logic sel_ctrl, sel_osc, sel_pll, sel_freq;

  assign sel_ctrl = (addr_i == ADDR_W'(OFF_CTRL));
  assign sel_osc  = (addr_i == ADDR_W'(OFF_OSC));
  assign sel_pll  = (addr_i == ADDR_W'(OFF_PLL));
  assign sel_freq = (addr_i == ADDR_W'(OFF_FREQ));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
      osc_q  <= OSC_RST;
      pll_q  <= PLL_RST;
      freq_q <= FREQ_RST;
    end else if (wr_i) begin
      if (sel_ctrl) ctrl_q <= wdata_i & CTRL_MASK;
      if (sel_osc)  osc_q  <= wdata_i & OSC_MASK;
      if (sel_pll)  pll_q  <= wdata_i & PLL_MASK;
      if (sel_freq) freq_q <= wdata_i & FREQ_MASK;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_ctrl) rdata_o = ctrl_q;
    if (sel_osc)  rdata_o = osc_q | (DW'(osc_stat_i) << OSC_STAT);
    if (sel_pll)  rdata_o = pll_q | (DW'(pla_stat_i) << PLA_STAT);
    if (sel_freq) rdata_o = freq_q;
  end

  assign ctrl_o = ctrl_q;
  assign osc_o  = osc_q;
  assign pll_o  = pll_q;
  assign freq_o = freq_q;
endmodule

// File: rtl/sysclk_ctrl.sv
module sysclk_ctrl
  import sysclk_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  input  logic               main_osc_ok_i,
  input  logic               pll_a_lock_i,
  output logic               bus_clk_en_o,
  output logic [N_TMR-1:0]   tmr_sel_o,
  output logic               main_osc_en_o,
  output logic               aux_osc_off_o,
  output logic               osc_tmr_en_o,
  output logic               pll_a_en_o,
  output logic               pll_b_en_o,
  output logic               pll_tmr_en_o,
  output logic [MUL_W-1:0]   pll_a_mul_o,
  output logic [SHIFT_W-1:0] pll_a_shift_o,
  output logic [MUL_W-1:0]   pll_b_mul_o
);
  logic [DW-1:0]    ctrl_w, osc_w, pll_w, freq_w;
  logic             osc_stat, pla_stat;
  logic             osc_ovr, pla_ovr;
  logic [DIV_W-1:0] div_act, div_cnt;

  sysclk_sync #(.STAGES(SYNC_STAGES)) u_sync_osc (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(main_osc_ok_i), .q_o(osc_stat)
  );

  sysclk_sync #(.STAGES(SYNC_STAGES)) u_sync_pla (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(pll_a_lock_i), .q_o(pla_stat)
  );

  sysclk_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .osc_stat_i(osc_stat),
    .pla_stat_i(pla_stat),
    .ctrl_o    (ctrl_w),
    .osc_o     (osc_w),
    .pll_o     (pll_w),
    .freq_o    (freq_w),
    .rdata_o   (rdata_o)
  );

  sysclk_busdiv #(.DIV_W(DIV_W)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .div_sel_i(ctrl_w[DIV_LSB +: DIV_W]),
    .ce_o     (bus_clk_en_o),
    .act_o    (div_act),
    .cnt_o    (div_cnt)
  );

  generate
    for (genvar t = 0; t < N_TMR; t++) begin : g_tsel
      assign tmr_sel_o[t] = ctrl_w[TSEL_LSB + TSEL_STEP*t];
    end
  endgenerate

  assign osc_ovr = osc_w[OSC_OVR];
  assign pla_ovr = pll_w[PLA_OVR];

  // main oscillator: enable honoured with override clear
  assign main_osc_en_o = osc_w[OSC_EN] & ~osc_ovr;
  assign aux_osc_off_o = osc_w[OSC_AOFF];
  assign osc_tmr_en_o  = osc_w[OSC_TMR];

  // primary PLL: enable honoured with override set, else hardware keeps it on
  assign pll_a_en_o   = pla_ovr ? pll_w[PLA_EN] : 1'b1;
  assign pll_b_en_o   = pll_w[PLB_EN];
  assign pll_tmr_en_o = pll_w[PL_TMR];

  assign pll_a_mul_o   = freq_w[AMUL_LSB +: MUL_W];
  assign pll_a_shift_o = freq_w[ASHIFT_LSB +: SHIFT_W];
  assign pll_b_mul_o   = freq_w[BMUL_LSB +: MUL_W];
endmodule

// File: rtl/sysclk_ctrl_chk.sv
module sysclk_ctrl_chk
  import sysclk_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [N_TMR-1:0]  tmr_sel_o,
  input logic [MUL_W-1:0]  pll_a_mul_o,
  input logic              pll_a_en_o,
  input logic              main_osc_en_o,
  input logic              osc_ovr,
  input logic              pla_ovr,
  input logic [DIV_W-1:0]  div_act,
  input logic [DIV_W-1:0]  div_cnt,
  input logic              bus_clk_en_o
);
  p_tsel_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tmr_sel_o) |-> $past(wr_i && addr_i == ADDR_W'(OFF_CTRL)));

  p_passthru_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_act == '0) |-> bus_clk_en_o);

  p_div_boundary_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(div_act) |-> $past(div_cnt == div_act));

  p_no_runt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_clk_en_o && div_act != '0) |=> !bus_clk_en_o);

  p_osc_ovr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_ovr |-> !main_osc_en_o);

  p_pla_hw_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pla_ovr |-> pll_a_en_o);

  p_freq_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pll_a_mul_o) |-> $past(wr_i && addr_i == ADDR_W'(OFF_FREQ)));
endmodule

bind sysclk_ctrl sysclk_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_i         (wr_i),
  .addr_i       (addr_i),
  .tmr_sel_o    (tmr_sel_o),
  .pll_a_mul_o  (pll_a_mul_o),
  .pll_a_en_o   (pll_a_en_o),
  .main_osc_en_o(main_osc_en_o),
  .osc_ovr      (osc_ovr),
  .pla_ovr      (pla_ovr),
  .div_act      (div_act),
  .div_cnt      (div_cnt),
  .bus_clk_en_o (bus_clk_en_o)
);

// File: tb/tb_sysclk_ctrl.sv
`timescale 1ns/1ps
module tb_sysclk_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        main_osc_ok_i = 1'b0;
  logic        pll_a_lock_i = 1'b0;
  logic        bus_clk_en_o;
  logic [7:0]  tmr_sel_o;
  logic        main_osc_en_o, aux_osc_off_o, osc_tmr_en_o;
  logic        pll_a_en_o, pll_b_en_o, pll_tmr_en_o;
  logic [5:0]  pll_a_mul_o, pll_b_mul_o;
  logic [2:0]  pll_a_shift_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  sysclk_ctrl dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o),
    .main_osc_ok_i(main_osc_ok_i), .pll_a_lock_i(pll_a_lock_i),
    .bus_clk_en_o(bus_clk_en_o), .tmr_sel_o(tmr_sel_o),
    .main_osc_en_o(main_osc_en_o), .aux_osc_off_o(aux_osc_off_o),
    .osc_tmr_en_o(osc_tmr_en_o), .pll_a_en_o(pll_a_en_o),
    .pll_b_en_o(pll_b_en_o), .pll_tmr_en_o(pll_tmr_en_o),
    .pll_a_mul_o(pll_a_mul_o), .pll_a_shift_o(pll_a_shift_o),
    .pll_b_mul_o(pll_b_mul_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  // drive at a falling edge, registers updated by the next falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr_i = a;
    #0.5;
    d = rdata_o;
  endtask

  task automatic t_reset_r1;
    logic [31:0] v;
    rd(8'h00, v); chk("R1 ctrl", v, 32'h0000_0000);
    rd(8'h0C, v); chk("R1 osc", v, 32'h0010_0002);
    rd(8'h10, v); chk("R1 pll", v, 32'h3000_0002);
    rd(8'h14, v); chk("R1 freq", v, 32'h0000_0000);
    for (int i = 0; i < 4; i++) begin
      chk("R1 bus_clk_en", {31'b0, bus_clk_en_o}, 32'h1);
      wait_neg(1);
    end
  endtask

  task automatic t_map_r2;
    logic [31:0] v;
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, v); chk("R2 unmapped 04", v, 32'h0);
    rd(8'h18, v); chk("R2 unmapped 18", v, 32'h0);
    rd(8'h00, v); chk("R2 ctrl untouched", v, 32'h0);
    rd(8'h14, v); chk("R2 freq untouched", v, 32'h0);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, v); chk("R2 ctrl mask", v, 32'h2AAA_E000);
    wr(8'h00, 32'h0);
    wait_neg(6);
  endtask

  task automatic t_tsel_r3;
    wr(8'h00, 32'h2AAA_8000); chk("R3 all", {24'b0, tmr_sel_o}, 32'hFF);
    wr(8'h00, 32'h0002_8000); chk("R3 t0 t1", {24'b0, tmr_sel_o}, 32'h03);
    wr(8'h00, 32'h2000_0000); chk("R3 t7", {24'b0, tmr_sel_o}, 32'h80);
    wr(8'h00, 32'h0);
    wait_neg(6);
  endtask

  task automatic t_div_r4(input int n);
    int cnt = 0;
    wr(8'h00, 32'(n) << 13);
    wait_neg(8);
    for (int i = 0; i < 12; i++) begin
      if (bus_clk_en_o) cnt++;
      wait_neg(1);
    end
    chk($sformatf("R4 pulses div %0d", n), 32'(cnt), 32'(12 / (n + 1)));
  endtask

  task automatic t_boundary_r5;
    int guard = 0;
    wr(8'h00, 32'h0000_6000);
    wait_neg(8);
    while (!bus_clk_en_o && guard < 8) begin wait_neg(1); guard++; end
    chk("R5 found pulse", {31'b0, bus_clk_en_o}, 32'h1);
    wr(8'h00, 32'h0);   // returns at N0+1
    chk("R5 N+1", {31'b0, bus_clk_en_o}, 32'h0);
    wait_neg(1); chk("R5 N+2", {31'b0, bus_clk_en_o}, 32'h0);
    wait_neg(1); chk("R5 N+3", {31'b0, bus_clk_en_o}, 32'h0);
    wait_neg(1); chk("R5 N+4", {31'b0, bus_clk_en_o}, 32'h1);
    wait_neg(1); chk("R5 N+5", {31'b0, bus_clk_en_o}, 32'h1);
  endtask

  task automatic t_osc_r6;
    chk("R6 reset en", {31'b0, main_osc_en_o}, 32'h1);
    wr(8'h0C, 32'h0000_0003); chk("R6 ovr blocks", {31'b0, main_osc_en_o}, 32'h0);
    wr(8'h0C, 32'h0000_0000); chk("R6 en clear", {31'b0, main_osc_en_o}, 32'h0);
    wr(8'h0C, 32'h0000_0002); chk("R6 en set", {31'b0, main_osc_en_o}, 32'h1);
    wr(8'h0C, 32'h0018_0002);
    chk("R6 aux off", {31'b0, aux_osc_off_o}, 32'h1);
    chk("R6 tmr en", {31'b0, osc_tmr_en_o}, 32'h1);
    wr(8'h0C, 32'h0000_0002);
    chk("R6 aux on", {31'b0, aux_osc_off_o}, 32'h0);
    chk("R6 tmr off", {31'b0, osc_tmr_en_o}, 32'h0);
  endtask

  task automatic t_pll_r7;
    chk("R7 reset", {31'b0, pll_a_en_o}, 32'h1);
    wr(8'h10, 32'h0000_0000); chk("R7 hw keeps on", {31'b0, pll_a_en_o}, 32'h1);
    wr(8'h10, 32'h0000_0001); chk("R7 ovr off", {31'b0, pll_a_en_o}, 32'h0);
    wr(8'h10, 32'h0000_0003); chk("R7 ovr on", {31'b0, pll_a_en_o}, 32'h1);
    wr(8'h10, 32'h1000_0001);
    chk("R7 pll_b", {31'b0, pll_b_en_o}, 32'h1);
    chk("R7 tmr", {31'b0, pll_tmr_en_o}, 32'h0);
    wr(8'h10, 32'h2000_0000);
    chk("R7 pll_b off", {31'b0, pll_b_en_o}, 32'h0);
    chk("R7 tmr on", {31'b0, pll_tmr_en_o}, 32'h1);
  endtask

  task automatic t_freq_r8;
    logic [31:0] v;
    wr(8'h14, 32'hAA1F_1507);
    chk("R8 a_mul", {26'b0, pll_a_mul_o}, 32'h15);
    chk("R8 a_shift", {29'b0, pll_a_shift_o}, 32'h7);
    chk("R8 b_mul", {26'b0, pll_b_mul_o}, 32'h2A);
    rd(8'h14, v); chk("R8 readback", v, 32'h2A00_1507);
  endtask

  task automatic t_status_r9;
    logic [31:0] v;
    wr(8'h0C, 32'h0000_0006);
    rd(8'h0C, v); chk("R9 osc stat ro", v & 32'h4, 32'h0);
    wr(8'h10, 32'h0000_0004);
    rd(8'h10, v); chk("R9 pll stat ro", v & 32'h4, 32'h0);
    main_osc_ok_i = 1'b1; pll_a_lock_i = 1'b1;
    wait_neg(1);
    rd(8'h0C, v); chk("R9 osc 1 edge", v & 32'h4, 32'h0);
    rd(8'h10, v); chk("R9 pll 1 edge", v & 32'h4, 32'h0);
    wait_neg(1);
    rd(8'h0C, v); chk("R9 osc 2 edges", v & 32'h4, 32'h4);
    rd(8'h10, v); chk("R9 pll 2 edges", v & 32'h4, 32'h4);
    wr(8'h10, 32'h0);
    rd(8'h10, v); chk("R9 pll stat kept", v & 32'h4, 32'h4);
  endtask

  initial begin
    wait_neg(3);
    rst_ni = 1'b1;
    wait_neg(1);
    t_reset_r1();
    t_map_r2();
    t_tsel_r3();
    for (int n = 0; n < 4; n++) t_div_r4(n);
    t_boundary_r5();
    t_osc_r6();
    t_pll_r7();
    t_freq_r8();
    t_status_r9();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule